// File: doc/BRIEF.md
# Masked Fixed-Priority Interrupt Arbiter

This unit gathers eight single-cycle interrupt request pulses into a pending register, qualifies them with an eight-bit enable mask and one global enable, and presents the index of the highest-numbered qualified source to a processor core. The core acknowledges the presented source, and that source's pending bit clears. No record of which source is in service is kept. Once a source has been acknowledged it drops out of arbitration. Any other pending source that is masked in can therefore interrupt its handler while the global enable is set. Software controls nesting by rewriting the mask inside each handler.

A small last-in-first-out status stack stores the mask and the global enable together as one word. A save operation pushes that word and turns the global enable off. A restore operation pops the word and brings back both values. A handler can therefore save, load a narrower mask, enable, do its work and restore.

The stack occupancy is tracked by a three-state machine. The states are `STK_EMPTY`, `STK_PART` (holding at least one word but not full) and `STK_FULL`.
- A valid push moves `STK_EMPTY` to `STK_PART`, or straight to `STK_FULL` when the depth is one.
- A valid push moves `STK_PART` to `STK_FULL` once the last free slot is taken.
- A valid pop moves `STK_PART` to `STK_EMPTY` when the only word is removed.
- A valid pop moves `STK_FULL` back to `STK_PART`, or to `STK_EMPTY` when the depth is one.
- A push in `STK_FULL` or a pop in `STK_EMPTY` keeps the state unchanged and raises the error flag.

Each cycle the control decode selects one operation, by precedence: `CTL_POP`, then `CTL_PUSH`, then `CTL_WRITE`, otherwise `CTL_IDLE`.

Top module: `prio_irq_unit`

## Requirements
- R1: After reset, the pending bits are 0, the mask is 0, the global enable is 0, the stack is empty, the error flag is 0 and `irq_o` is 0.
- R2: A high `req_i[i]` at a clock edge sets pending bit i, and that bit stays set until its source is acknowledged.
- R3: `irq_o` is high exactly when the global enable is 1 and the bitwise AND of pending and mask is non-zero.
- R4: When `irq_o` is high, `idx_o` is the highest set bit of pending AND mask. Bit 7 has the highest priority and bit 0 the lowest.
- R5: `ack_i` while `irq_o` is high clears only the pending bit at `idx_o`. `ack_i` while `irq_o` is low changes nothing.
- R6: If a request for a source arrives in the same cycle as the acknowledge of that source, its pending bit stays set.
- R7: No in-service state is kept. After the acknowledge of a high source, a lower pending source that is masked in raises `irq_o` in the next cycle.
- R8: `gie_set_i` sets the global enable and `gie_clr_i` clears it. If both are high in the same cycle, the clear wins.
- R9: `mask_we_i` loads `mask_wdata_i` into the mask. Mask bit i set to 1 enables source i.
- R10: `save_i` pushes the word {global enable, mask}, clears the global enable and leaves the mask unchanged.
- R11: `restore_i` pops the most recent word and restores both the mask and the global enable. The stack is last-in-first-out and holds 4 words.
- R12: A save when 4 words are stored, or a restore when the stack is empty, sets the sticky `stk_err_o` and changes neither the mask, the global enable nor the stack. Only reset clears `stk_err_o`.
- R13: When several control inputs are high in one cycle, only the highest-ranked operation is applied. The order is restore, then save, then mask write together with the enable set or clear. A request and an acknowledge are still applied alongside any of these.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 8 | Request pulses, one per source |
| ack_i | input | 1 | Acknowledge of the presented source |
| mask_we_i | input | 1 | Mask write strobe |
| mask_wdata_i | input | 8 | Mask write data |
| gie_set_i | input | 1 | Global enable set |
| gie_clr_i | input | 1 | Global enable clear |
| save_i | input | 1 | Push {enable, mask} and clear enable |
| restore_i | input | 1 | Pop {enable, mask} |
| irq_o | output | 1 | Interrupt request to the core |
| idx_o | output | 3 | Index of the winning source |
| pend_o | output | 8 | Pending register |
| mask_o | output | 8 | Mask register |
| gie_o | output | 1 | Global enable |
| stk_err_o | output | 1 | Sticky stack overflow or underflow flag |

## Verification
Every register update takes effect at the edge on which its input is sampled. `pend_o`, `mask_o`, `gie_o` and `stk_err_o` therefore show the new value one cycle after the stimulus, and `irq_o` and `idx_o` follow combinationally in that same cycle. The bench drives inputs on the falling edge and advances a behavioural model at the rising edge. It then compares every output on the next falling edge, which is one full register stage after the stimulus. An acknowledge is judged against the `irq_o` and `idx_o` values that were visible while it was driven.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

    typedef enum logic [1:0] {
        STK_EMPTY = 2'd0,
        STK_PART  = 2'd1,
        STK_FULL  = 2'd2
    } stk_state_e;

    typedef enum logic [1:0] {
        CTL_IDLE  = 2'd0,
        CTL_POP   = 2'd1,
        CTL_PUSH  = 2'd2,
        CTL_WRITE = 2'd3
    } ctl_op_e;

endpackage

// File: rtl/irq_pend_reg.sv
module irq_pend_reg #(
    parameter int unsigned N_SRC = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] req_i,
    input  logic [N_SRC-1:0] clr_i,
    output logic [N_SRC-1:0] pend_o
);

    for (genvar g = 0; g < N_SRC; g++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                pend_o[g] <= 1'b0;
            else if (req_i[g])
                pend_o[g] <= 1'b1;
            else if (clr_i[g])
                pend_o[g] <= 1'b0;
        end

        // R2: a request sets its bit (this also covers the R6 collision with a clear)
        p_req_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
            req_i[g] |=> pend_o[g]);

        // R5: a clear with no new request drops the bit
        p_clr_drops_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[g] && !req_i[g]) |=> !pend_o[g]);
    end

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
    parameter int unsigned N_SRC = 8,
    localparam int unsigned IW = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic [N_SRC-1:0] pend_i,
    input  logic [N_SRC-1:0] mask_i,
    input  logic             gie_i,
    output logic             irq_o,
    output logic [IW-1:0]    idx_o
);

    logic [N_SRC-1:0] hit;

    always_comb begin
        hit   = pend_i & mask_i;
        idx_o = '0;
        // Scan from the lowest bit up, so the highest set bit wins.
        for (int i = 0; i < N_SRC; i++) begin
            if (hit[i]) idx_o = IW'(i);
        end
        irq_o = gie_i && (|hit);
    end

endmodule

// File: rtl/irq_status_ctl.sv
module irq_status_ctl
    import irq_arb_pkg::*;
#(
    parameter int unsigned N_SRC     = 8,
    parameter int unsigned STK_DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mask_we_i,
    input  logic [N_SRC-1:0] mask_wdata_i,
    input  logic             gie_set_i,
    input  logic             gie_clr_i,
    input  logic             save_i,
    input  logic             restore_i,
    output logic [N_SRC-1:0] mask_o,
    output logic             gie_o,
    output logic             err_o
);

    localparam int unsigned CW = $clog2(STK_DEPTH + 1);
    localparam int unsigned AW = (STK_DEPTH > 1) ? $clog2(STK_DEPTH) : 1;
    localparam int unsigned WW = N_SRC + 1;

    stk_state_e       state_q, state_d;
    ctl_op_e          op;
    logic [CW-1:0]    cnt_q;
    logic [CW-1:0]    top_idx;
    logic [WW-1:0]    stk_q [STK_DEPTH];
    logic             push_ok, pop_ok;

    // Control decode: restore outranks save, and save outranks writes.
    always_comb begin
        if (restore_i)
            op = CTL_POP;
        else if (save_i)
            op = CTL_PUSH;
        else if (mask_we_i || gie_set_i || gie_clr_i)
            op = CTL_WRITE;
        else
            op = CTL_IDLE;
        push_ok = (op == CTL_PUSH) && (state_q != STK_FULL);
        pop_ok  = (op == CTL_POP)  && (state_q != STK_EMPTY);
        top_idx = cnt_q - CW'(1);
    end

    // Next-state logic for the stack occupancy
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            STK_EMPTY: if (push_ok)
                state_d = (STK_DEPTH == 1) ? STK_FULL : STK_PART;
            STK_PART: begin
                if (push_ok && cnt_q == CW'(STK_DEPTH - 1))
                    state_d = STK_FULL;
                else if (pop_ok && cnt_q == CW'(1))
                    state_d = STK_EMPTY;
            end
            STK_FULL: if (pop_ok)
                state_d = (STK_DEPTH == 1) ? STK_EMPTY : STK_PART;
            default: state_d = STK_EMPTY;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= STK_EMPTY;
        else
            state_q <= state_d;
    end

    // Output and stack registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_o <= '0;
            gie_o  <= 1'b0;
            err_o  <= 1'b0;
            cnt_q  <= '0;
        end else begin
            unique case (op)
                CTL_POP: begin
                    if (pop_ok) begin
                        {gie_o, mask_o} <= stk_q[top_idx[AW-1:0]];
                        cnt_q           <= top_idx;
                    end else begin
                        err_o <= 1'b1;
                    end
                end
                CTL_PUSH: begin
                    if (push_ok) begin
                        gie_o <= 1'b0;
                        cnt_q <= cnt_q + CW'(1);
                    end else begin
                        err_o <= 1'b1;
                    end
                end
                CTL_WRITE: begin
                    if (mask_we_i) mask_o <= mask_wdata_i;
                    if (gie_clr_i)
                        gie_o <= 1'b0;
                    else if (gie_set_i)
                        gie_o <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // Stack storage (needs no reset: an entry is read only after it was written)
    always_ff @(posedge clk) begin
        if (push_ok) stk_q[cnt_q[AW-1:0]] <= {gie_o, mask_o};
    end

    // R10: a save that fits turns the global enable off and keeps the mask
    p_save_drops_gie_r10: assert property (@(posedge clk) disable iff (!rst_n)
        push_ok |=> (!gie_o && $stable(mask_o)));

    // R12: an overflow leaves the mask and enable alone and raises the flag
    p_full_save_keeps_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (op == CTL_PUSH && state_q == STK_FULL) |=> ($stable(mask_o) && $stable(gie_o) && err_o));

    // R12: an underflow leaves the mask and enable alone and raises the flag
    p_empty_pop_keeps_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (op == CTL_POP && state_q == STK_EMPTY) |=> ($stable(mask_o) && $stable(gie_o) && err_o));

    // R12: the error flag is sticky
    p_err_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);

    // R11: the occupancy never exceeds the stack depth
    p_cnt_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(STK_DEPTH));

endmodule

// File: rtl/prio_irq_unit.sv
module prio_irq_unit #(
    parameter int unsigned N_SRC     = 8,
    parameter int unsigned STK_DEPTH = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_SRC-1:0]          req_i,
    input  logic                      ack_i,
    input  logic                      mask_we_i,
    input  logic [N_SRC-1:0]          mask_wdata_i,
    input  logic                      gie_set_i,
    input  logic                      gie_clr_i,
    input  logic                      save_i,
    input  logic                      restore_i,
    output logic                      irq_o,
    output logic [$clog2(N_SRC)-1:0]  idx_o,
    output logic [N_SRC-1:0]          pend_o,
    output logic [N_SRC-1:0]          mask_o,
    output logic                      gie_o,
    output logic                      stk_err_o
);

    logic [N_SRC-1:0] clr;

    // An acknowledge counts only while a request is being presented.
    always_comb begin
        clr = '0;
        if (ack_i && irq_o) clr[idx_o] = 1'b1;
    end

    irq_pend_reg #(.N_SRC(N_SRC)) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (req_i),
        .clr_i  (clr),
        .pend_o (pend_o)
    );

    irq_status_ctl #(.N_SRC(N_SRC), .STK_DEPTH(STK_DEPTH)) u_ctl (
        .clk          (clk),
        .rst_n        (rst_n),
        .mask_we_i    (mask_we_i),
        .mask_wdata_i (mask_wdata_i),
        .gie_set_i    (gie_set_i),
        .gie_clr_i    (gie_clr_i),
        .save_i       (save_i),
        .restore_i    (restore_i),
        .mask_o       (mask_o),
        .gie_o        (gie_o),
        .err_o        (stk_err_o)
    );

    irq_prio_enc #(.N_SRC(N_SRC)) u_enc (
        .pend_i (pend_o),
        .mask_i (mask_o),
        .gie_i  (gie_o),
        .irq_o  (irq_o),
        .idx_o  (idx_o)
    );

    // R3: no request is presented while the global enable is off
    p_irq_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !gie_o |-> !irq_o);

    // R4: the presented source is both pending and masked in
    p_idx_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (pend_o[idx_o] && mask_o[idx_o]));

endmodule

// File: tb/prio_irq_unit_test.sv
`timescale 1ns/1ps
module prio_irq_unit_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] req = '0;
    logic       ack = 1'b0, mwe = 1'b0, gset = 1'b0, gclr = 1'b0, sv = 1'b0, rs = 1'b0;
    logic [7:0] mwd = '0;
    logic       irq, gie, err;
    logic [2:0] idx;
    logic [7:0] pend, mask;

    int checks = 0;
    int errors = 0;

    // Behavioural reference state
    logic [7:0] m_pend = '0, m_mask = '0;
    logic       m_gie = 1'b0, m_err = 1'b0;
    logic [8:0] m_stk [$];

    always #2.5 clk = ~clk;

    prio_irq_unit uut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .ack_i(ack),
        .mask_we_i(mwe), .mask_wdata_i(mwd), .gie_set_i(gset), .gie_clr_i(gclr),
        .save_i(sv), .restore_i(rs), .irq_o(irq), .idx_o(idx), .pend_o(pend),
        .mask_o(mask), .gie_o(gie), .stk_err_o(err)
    );

    function automatic logic m_irq();
        return m_gie && ((m_pend & m_mask) != 0);
    endfunction

    function automatic int m_idx();
        int r = 0;
        for (int i = 0; i < 8; i++) if ((m_pend[i] & m_mask[i]) != 0) r = i;
        return r;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Advance the model with the inputs held across the rising edge.
    task automatic model_step();
        logic [7:0] clrv = '0;
        if (ack && m_irq()) clrv[m_idx()] = 1'b1;
        m_pend = (m_pend & ~clrv) | req;
        if (rs) begin
            if (m_stk.size() == 0) m_err = 1'b1;
            else {m_gie, m_mask} = m_stk.pop_back();
        end else if (sv) begin
            if (m_stk.size() == 4) m_err = 1'b1;
            else begin
                m_stk.push_back({m_gie, m_mask});
                m_gie = 1'b0;
            end
        end else begin
            if (mwe) m_mask = mwd;
            if (gclr) m_gie = 1'b0;
            else if (gset) m_gie = 1'b1;
        end
    endtask

    task automatic compare_all();
        check(pend == m_pend, "R2 R5 R6 pending", pend, m_pend);
        check(mask == m_mask, "R9 R11 mask", mask, m_mask);
        check(gie == m_gie, "R8 R10 R11 enable", gie, m_gie);
        check(irq == m_irq(), "R3 R7 irq", irq, m_irq());
        if (m_irq()) check(idx == 3'(m_idx()), "R4 index", idx, m_idx());
        check(err == m_err, "R12 error flag", err, m_err);
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all();
        req = '0; ack = 0; mwe = 0; mwd = '0; gset = 0; gclr = 0; sv = 0; rs = 0;
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check(pend == 0 && mask == 0 && gie == 0 && err == 0 && irq == 0,
              "R1 reset", {pend, mask, gie, err, irq}, 0);

        // R9, R8: open every source and enable
        mwe = 1; mwd = 8'hFF; gset = 1; tick();
        // R2, R4: highest and lowest request together, bit 7 wins
        req = 8'h81; tick();
        check(irq && idx == 3'd7, "R4 bit 7 first", idx, 7);
        // R5, R7: ack bit 7, bit 0 is presented at once
        ack = 1; tick();
        check(irq && idx == 3'd0 && pend == 8'h01, "R7 lower preempts", pend, 8'h01);
        // R6: re-request bit 0 while it is acknowledged
        ack = 1; req = 8'h01; tick();
        check(pend == 8'h01, "R6 request kept", pend, 8'h01);
        ack = 1; tick();
        // R10: save, then narrow the mask to bits 7..4 as inside a bit-3 handler
        sv = 1; tick();
        check(!gie && mask == 8'hFF, "R10 save", {gie, mask}, 8'hFF);
        mwe = 1; mwd = 8'hF0; gset = 1; tick();
        req = 8'h08; tick();
        check(!irq, "R3 masked bit 3", irq, 0);
        req = 8'h20; tick();
        check(irq && idx == 3'd5, "R4 bit 5 in", idx, 5);
        ack = 1; tick();
        // R11: restore brings back the full mask and enable
        rs = 1; tick();
        check(gie && mask == 8'hFF && irq && idx == 3'd3, "R11 restore", mask, 8'hFF);
        // R5: ack with the enable off changes nothing
        gclr = 1; tick();
        ack = 1; tick();
        check(pend == 8'h08, "R5 ack ignored", pend, 8'h08);
        // R8: clear beats set
        gset = 1; gclr = 1; tick();
        check(!gie, "R8 clear wins", gie, 0);
        // R11, R12: fill four levels with distinct masks, overflow, then LIFO unwind
        for (int k = 0; k < 4; k++) begin
            mwe = 1; mwd = 8'(k + 1); tick();
            sv = 1; tick();
        end
        mwe = 1; mwd = 8'hAA; tick();
        sv = 1; tick();
        check(err && mask == 8'hAA, "R12 overflow", {err, mask}, 9'h1AA);
        for (int k = 3; k >= 0; k--) begin
            rs = 1; tick();
            check(mask == 8'(k + 1), "R11 LIFO order", mask, k + 1);
        end
        rs = 1; tick();
        check(err && mask == 8'h01, "R12 underflow", mask, 1);
        // R13: restore outranks save and write; save outranks write
        mwe = 1; mwd = 8'h3C; gset = 1; tick();
        sv = 1; rs = 1; mwe = 1; mwd = 8'h11; tick();
        check(mask == 8'h3C, "R13 restore ranks first", mask, 8'h3C);
        sv = 1; mwe = 1; mwd = 8'h22; gset = 1; tick();
        check(mask == 8'h3C && !gie, "R13 save over write", {gie, mask}, 8'h3C);
        rs = 1; tick();

        // Mixed traffic against the model
        for (int n = 0; n < 4000; n++) begin
            int r = $urandom_range(0, 99);
            req  = ($urandom_range(0, 3) == 0) ? 8'($urandom) & 8'($urandom) : 8'h00;
            ack  = ($urandom_range(0, 2) == 0);
            mwe  = (r < 8);
            mwd  = 8'($urandom);
            gset = (r >= 8 && r < 16);
            gclr = (r >= 16 && r < 19);
            sv   = (r >= 19 && r < 24);
            rs   = (r >= 24 && r < 29);
            tick();
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule